// File: doc/BRIEF.md
# Strobed Parallel Register Bus Slave

This block lets a host controller reach a small bank of peripheral registers over an asynchronous parallel bus. The bus carries an 8-bit data path, a 4-bit register address, a read/write select and an active-low enable strobe. None of these lines is related to the block clock. The block passes the strobe, direction and address through a two-stage synchronizer. It commits a write once, when it sees the synchronized strobe fall. It drives read data only while a read strobe is held.

The data path is split at the block edge into an input, an output and an output enable, so the pad ring can build the bidirectional pins. The register bank is shared by the peripherals behind it: a card UART, a clock generator, an activation sequencer and an auxiliary RAM. Their contents reach them through the flat `regs_o` vector. Address 0 holds a read-only status register of pending event flags. One-cycle pulses on `evt_i` set these flags. Each pending flag holds the active-low `irq_n` line low.

A status read returns the flags as they stood when the read began. It clears exactly those flags when the strobe ends, so an event that lands during the read stays pending. Addresses 1 to `NUM_RW` are read/write registers. Every other address is unmapped.

Top module: `strobe_reg_slave`

## Requirements
- R1: After reset, every read/write register is 0x00, `host_d_oe` is 0 and `irq_n` is 1.
- R2: A write (`bus_rw_i`=0) to address k in 1..`NUM_RW` stores `host_d_i` into register k. Register k appears on `regs_o[8k-1 -: 8]`, so address 1 occupies bits [7:0].
- R3: While `bus_en_n_i` is low and `bus_rw_i` is high, and once the synchronizer delay has passed, `host_d_oe` is 1 and `host_d_o` carries the addressed register.
- R4: `host_d_oe` is 0 whenever the strobe is high or the access is a write, allowing for the synchronizer delay.
- R5: A read of an unmapped address (`NUM_RW`+1 to 15) returns 0xFF.
- R6: A write to an unmapped address changes no register.
- R7: A one-cycle pulse on `evt_i[j]` sets status flag j. `irq_n` is low while any flag is set.
- R8: A read of address 0 returns the flags pending at the start of the strobe in bits [`NFLAG`-1:0], with the upper bits zero.
- R9: When a status read strobe ends, only the flags it returned are cleared. A flag raised during the strobe stays set. `irq_n` returns high if nothing remains pending.
- R10: A write to address 0 is ignored. The flags and all registers are unchanged.
- R11: A write commits once per strobe. Data that changes while the strobe stays low is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n_i | input | 1 | Host access strobe, active low, asynchronous |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_addr_i | input | 4 | Register address |
| host_d_i | input | 8 | Write data from the host |
| host_d_o | output | 8 | Read data to the host |
| host_d_oe | output | 1 | Drive enable for the data pins |
| evt_i | input | NFLAG | Event pulses that set status flags |
| irq_n | output | 1 | Interrupt, low while any flag is pending |
| regs_o | output | 8*NUM_RW | Register contents for the peripherals |

## Verification
The bench sweeps all sixteen addresses, first with writes and then with reads. A decoder that aliases an unmapped address onto a real register, or that returns zero instead of 0xFF, shows up as a wrong read-back. The bench holds a write strobe low while the data changes. A design that stores data on the level of the strobe rather than on its falling edge keeps the late value. The bench also raises an event in the middle of a status read. A design that clears all flags when the strobe ends, instead of only the returned snapshot, loses that event and releases `irq_n` early. Writes to the status address must leave the pending flags untouched.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;
  typedef struct packed {
    logic  en_n;
    logic  rw;
    addr_t addr;
  } bus_ctl_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/srs_status.sv
module srs_status #(
  parameter int unsigned NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             stat_rd,
  output logic [NFLAG-1:0] snap,
  output logic             irq_n
);
  logic [NFLAG-1:0] pending, pend_nxt;
  logic             stat_rd_d;
  logic             rd_end;

  assign rd_end = stat_rd_d & ~stat_rd;

  always_comb begin
    pend_nxt = pending;
    if (rd_end) pend_nxt = pend_nxt & ~snap;
    pend_nxt = pend_nxt | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= '0;
      snap      <= '0;
      stat_rd_d <= 1'b0;
    end else begin
      pending   <= pend_nxt;
      stat_rd_d <= stat_rd;
      if (!stat_rd) snap <= pend_nxt;
    end
  end

  assign irq_n = ~|pending;
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
  import srs_pkg::*;
#(
  parameter int unsigned NUM_RW    = 6,
  parameter int unsigned NFLAG     = 4,
  parameter int unsigned STAT_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  addr_t              addr,
  input  byte_t              wdata,
  input  logic [NFLAG-1:0]   stat,
  output byte_t              rdata,
  output logic [DW*NUM_RW-1:0] regs_flat
);
  byte_t regs [NUM_RW];

  for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
    localparam addr_t MY_ADDR = addr_t'(k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     regs[k] <= '0;
      else if (we && addr == MY_ADDR) regs[k] <= wdata;
    end
    assign regs_flat[DW*k +: DW] = regs[k];
  end

  always_comb begin
    rdata = '1;
    if (addr == addr_t'(STAT_ADDR)) begin
      rdata = '0;
      rdata[NFLAG-1:0] = stat;
    end else begin
      for (int k = 0; k < NUM_RW; k++)
        if (addr == addr_t'(k + 1)) rdata = regs[k];
    end
  end
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import srs_pkg::*;
#(
  parameter int unsigned NUM_RW    = 6,
  parameter int unsigned NFLAG     = 4,
  parameter int unsigned STAT_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en_n_i,
  input  logic                   bus_rw_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic [DW-1:0]          host_d_i,
  output logic [DW-1:0]          host_d_o,
  output logic                   host_d_oe,
  input  logic [NFLAG-1:0]       evt_i,
  output logic                   irq_n,
  output logic [DW*NUM_RW-1:0]   regs_o
);
  localparam int unsigned CW = $bits(bus_ctl_t);
  localparam bus_ctl_t CTL_IDLE = '{en_n: 1'b1, rw: 1'b1, addr: '0};

  bus_ctl_t ctl_raw, ctl_s;
  logic     en_d;
  logic     en_fall, wr_commit, rd_active, stat_rd;
  logic [NFLAG-1:0] stat_snap;

  assign ctl_raw = '{en_n: bus_en_n_i, rw: bus_rw_i, addr: bus_addr_i};

  srs_sync #(.W(CW), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b1;
    else        en_d <= ctl_s.en_n;
  end

  assign en_fall   = en_d & ~ctl_s.en_n;
  assign wr_commit = en_fall & ~ctl_s.rw & (ctl_s.addr != addr_t'(STAT_ADDR));
  assign rd_active = ~ctl_s.en_n & ctl_s.rw;
  assign stat_rd   = rd_active & (ctl_s.addr == addr_t'(STAT_ADDR));

  srs_status #(.NFLAG(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .stat_rd(stat_rd),
    .snap(stat_snap), .irq_n(irq_n)
  );

  srs_regbank #(.NUM_RW(NUM_RW), .NFLAG(NFLAG), .STAT_ADDR(STAT_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .addr(ctl_s.addr),
    .wdata(host_d_i), .stat(stat_snap), .rdata(host_d_o), .regs_flat(regs_o)
  );

  assign host_d_oe = rd_active;
endmodule

// File: rtl/strobe_reg_slave_chk.sv
module strobe_reg_slave_chk #(
  parameter int unsigned NUM_RW = 6,
  parameter int unsigned NFLAG  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en_n_i,
  input logic                 bus_rw_i,
  input logic [3:0]           bus_addr_i,
  input logic [7:0]           host_d_o,
  input logic                 host_d_oe,
  input logic [NFLAG-1:0]     evt_i,
  input logic                 irq_n,
  input logic [8*NUM_RW-1:0]  regs_o
);
  // R4
  oe_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_d_oe |-> (!$past(bus_en_n_i, 2) && $past(bus_rw_i, 2)));
  // R5
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_d_oe && ($past(bus_addr_i, 2) > 4'(NUM_RW))) |-> (host_d_o == 8'hFF));
  // R7
  evt_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> !irq_n);
  // R11
  reg_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> (!$past(bus_rw_i, 3) && $past(bus_en_n_i, 4) && !$past(bus_en_n_i, 3)));
endmodule

bind strobe_reg_slave strobe_reg_slave_chk #(.NUM_RW(NUM_RW), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en_n_i(bus_en_n_i), .bus_rw_i(bus_rw_i),
  .bus_addr_i(bus_addr_i), .host_d_o(host_d_o), .host_d_oe(host_d_oe),
  .evt_i(evt_i), .irq_n(irq_n), .regs_o(regs_o)
);

// File: tb/test_strobe_reg_slave.sv
`timescale 1ns/1ps
module test_strobe_reg_slave;
  localparam int NUM_RW = 6;
  localparam int NFLAG  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, rw = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe, irq_n;
  logic [NFLAG-1:0] evt = '0;
  logic [8*NUM_RW-1:0] regs;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  strobe_reg_slave #(.NUM_RW(NUM_RW), .NFLAG(NFLAG)) i_strobe_reg_slave (
    .clk(clk), .rst_n(rst_n), .bus_en_n_i(en_n), .bus_rw_i(rw),
    .bus_addr_i(addr), .host_d_i(din), .host_d_o(dout), .host_d_oe(oe),
    .evt_i(evt), .irq_n(irq_n), .regs_o(regs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; rw = 1'b0; din = d;
    @(negedge clk); en_n = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R4 oe during write", oe, 0);
    end
    en_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; rw = 1'b1;
    @(negedge clk); en_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 oe during read", oe, 1);
    d = dout;
    en_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 oe after read", oe, 0);
  endtask

  task automatic pulse_evt(input logic [NFLAG-1:0] v);
    evt = v; @(negedge clk); evt = '0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 regs", regs, 0);
    check("R1 oe", oe, 0);
    check("R1 irq_n", irq_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 regs after release", regs, 0);

    for (int a = 0; a < 16; a++) model[a] = (a >= 1 && a <= NUM_RW) ? 8'h00 : 8'hFF;
    model[0] = 8'h00;

    // R2 R6 R10 write sweep over all addresses
    for (int a = 0; a < 16; a++) begin
      bus_write(4'(a), 8'(a * 37 + 5));
      if (a >= 1 && a <= NUM_RW) model[a] = 8'(a * 37 + 5);
      for (int k = 1; k <= NUM_RW; k++)
        check("R2/R6/R10 regs_o slice", regs[8*k-1 -: 8], model[k]);
    end
    check("R10 irq_n after status write", irq_n, 1);

    // R3 R5 R8 read sweep
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), r);
      if (a == 0) check("R8 empty status", r, 0);
      else if (a <= NUM_RW) check("R3 readback", r, model[a]);
      else check("R5 unmapped reads FF", r, 8'hFF);
    end

    // second pattern: inverted data
    for (int a = 1; a <= NUM_RW; a++) begin
      bus_write(4'(a), ~8'(a * 37 + 5));
      model[a] = ~8'(a * 37 + 5);
    end
    for (int a = 1; a <= NUM_RW; a++) begin
      bus_read(4'(a), r);
      check("R3 readback inverted", r, model[a]);
    end

    // R11 data changes during a held strobe
    addr = 4'd2; rw = 1'b0; din = 8'h3C;
    @(negedge clk); en_n = 1'b0;
    repeat (5) @(negedge clk);
    din = 8'hC3;
    repeat (6) @(negedge clk);
    en_n = 1'b1;
    repeat (5) @(negedge clk);
    model[2] = 8'h3C;
    check("R11 single commit", regs[15:8], 8'h3C);

    // R7 event flags and irq
    pulse_evt(4'b0101);
    @(negedge clk);
    check("R7 irq low", irq_n, 0);
    // R10 status write does not clear flags
    bus_write(4'd0, 8'h00);
    check("R10 irq still low", irq_n, 0);

    // R8 R9 status read with an event during the strobe
    addr = 4'd0; rw = 1'b1;
    @(negedge clk); en_n = 1'b0;
    repeat (4) @(negedge clk);
    pulse_evt(4'b1000);
    repeat (3) @(negedge clk);
    check("R8 snapshot", dout, 8'h05);
    en_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 irq held by new flag", irq_n, 0);
    bus_read(4'd0, r);
    check("R9 remaining flag", r, 8'h08);
    check("R9 irq released", irq_n, 1);
    bus_read(4'd0, r);
    check("R9 flags empty", r, 8'h00);

    // all flags single at a time
    for (int j = 0; j < NFLAG; j++) begin
      pulse_evt(4'(1 << j));
      @(negedge clk);
      check("R7 irq per flag", irq_n, 0);
      bus_read(4'd0, r);
      check("R8 per flag", r, 8'(1 << j));
      check("R9 irq per flag", irq_n, 1);
    end

    for (int k = 1; k <= NUM_RW; k++)
      check("R2 final regs", regs[8*k-1 -: 8], model[k]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule